// File: doc/BRIEF.md
# Latched Line-Switch State Controller

This block is the digital control for the switch array of a telephone line card. Three mode inputs select a line state: ring, test-in and test-out. The block drives on/off enables for five switch groups: break, ring, ring-test, test-in and test-out. A hold input freezes the mode inputs. While it is low they flow straight through. On the first clock edge where it is seen high, their value is captured and held for as long as it stays high.

A three-way shutdown control sits outside the hold path, and the hold input never affects it. It is encoded as driven low, driven high or released, and arrives as a level pin plus a released flag. Driven low, it forces every group off. Driven high, it disables thermal protection, so the thermal-fault flag is ignored. Released, it arms thermal protection: a fault trips every group off. The trip is sticky until the fault flag clears. The outputs then return to the state that is held, or to the mode inputs if nothing is held.

The design is synchronous and all outputs are registered. A state register holds one of seven named states: ST_ALL_OFF, ST_IDLE, ST_TEST_OUT, ST_TEST_IN, ST_TEST_BOTH, ST_RING and ST_RING_TEST. It has three named transitions. RESET_ENTRY goes to ST_ALL_OFF on synchronous reset. OVERRIDE_OFF goes to ST_ALL_OFF from any state on a forced-low control or a thermal trip. DECODE_MOVE goes from any state to the decode of the effective mode on every other edge.

Top module: `lsw_ctrl`

## Requirements
- R1: Synchronous reset puts every switch enable off (sw_en = 5'b00000) and clears the hold register; after reset the block is in the transparent condition.
- R2: With latch_en low, an edge with mode_in = {ring, test_in, test_out} gives the following sw_en one cycle later: 000 idle (bit 0 = break only), 001 test-out (bit 4 only), 010 test-in (bit 3 only), 011 both tests (bits 4 and 3), 100 power ringing (bit 1 only), 101 ringing-generator test (bit 2 only).
- R3: mode_in values 110 and 111 decode to all groups off.
- R4: At the first edge where latch_en is seen high, mode_in at that edge is captured and becomes the effective mode.
- R5: While latch_en stays high on following edges, changes on mode_in have no effect on sw_en.
- R6: With sd_float = 0 and sd_drive = 0, sw_en is all off one cycle later, whatever mode_in and latch_en are. The hold register keeps working underneath, so a mode captured during the override appears once the override ends.
- R7: With sd_float = 0 and sd_drive = 1, thermal_fault has no effect on sw_en, and any existing trip is cleared.
- R8: With sd_float = 1 and thermal_fault = 1, sw_en is all off one cycle later. The trip persists through a forced-low interval and ends at the first edge where thermal_fault is 0. From that edge the outputs show the effective mode again.
- R9: After latch_en returns low, sw_en tracks mode_in again with one cycle of latency.
- R10: At most one group is on at any time. The only exception is the test-in plus test-out pair (5'b11000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_in | input | 3 | Mode select {ring, test_in, test_out} |
| latch_en | input | 1 | 0 = transparent, 1 = hold captured mode |
| sd_drive | input | 1 | Shutdown control level when not released |
| sd_float | input | 1 | 1 = shutdown control released (thermal protection armed) |
| thermal_fault | input | 1 | Thermal fault flag |
| sw_en | output | 5 | Group enables: bit0 break, bit1 ring, bit2 ring-test, bit3 test-in, bit4 test-out |

## Verification
The block has no size parameters beyond its fixed mode and group widths, so the bench builds it with the package defaults. A three-bit mode and five groups make the whole mode space cheap to cover. Directed sweeps reach all eight codes in the transparent condition, including the two unassigned ones. The random phase mixes hold, shutdown and fault inputs so that captures fall during overrides and trips straddle forced-low intervals.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
    localparam int MODE_W   = 3;
    localparam int GROUPS   = 5;
    localparam int G_BREAK  = 0;
    localparam int G_RING   = 1;
    localparam int G_RTEST  = 2;
    localparam int G_TIN    = 3;
    localparam int G_TOUT   = 4;

    typedef enum logic [2:0] {
        ST_ALL_OFF   = 3'd0,
        ST_IDLE      = 3'd1,
        ST_TEST_OUT  = 3'd2,
        ST_TEST_IN   = 3'd3,
        ST_TEST_BOTH = 3'd4,
        ST_RING      = 3'd5,
        ST_RING_TEST = 3'd6
    } line_state_t;

    // mode = {ring, test_in, test_out}
    function automatic line_state_t mode_to_state(input logic [MODE_W-1:0] m);
        line_state_t s;
        case (m)
            3'b000:  s = ST_IDLE;
            3'b001:  s = ST_TEST_OUT;
            3'b010:  s = ST_TEST_IN;
            3'b011:  s = ST_TEST_BOTH;
            3'b100:  s = ST_RING;
            3'b101:  s = ST_RING_TEST;
            default: s = ST_ALL_OFF;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/lsw_mode_latch.sv
module lsw_mode_latch #(
    parameter int W = lsw_pkg::MODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_req,
    input  logic [W-1:0] mode_d,
    output logic [W-1:0] mode_eff
);
    logic         hold_q;
    logic [W-1:0] held_q;
    logic         holding;

    // Holding starts on the edge after hold_req is first seen high.
    assign holding  = hold_req & hold_q;
    assign mode_eff = holding ? held_q : mode_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            held_q <= '0;
        end else begin
            hold_q <= hold_req;
            held_q <= mode_eff;
        end
    end
endmodule

// File: rtl/lsw_thermal_trip.sv
module lsw_thermal_trip (
    input  logic clk,
    input  logic rst,
    input  logic fault,
    input  logic ctl_float,
    input  logic ctl_level,
    output logic trip_now
);
    logic trip_q;

    // Armed only when released; kept through forced-low; cleared when the
    // fault goes away or when protection is disabled by a driven-high control.
    assign trip_now = fault & (ctl_float | (trip_q & ~ctl_level));

    always_ff @(posedge clk) begin
        if (rst) trip_q <= 1'b0;
        else     trip_q <= trip_now;
    end
endmodule

// File: rtl/lsw_group_drive.sv
module lsw_group_drive
    import lsw_pkg::*;
(
    input  line_state_t              state,
    output logic [GROUPS-1:0]        en
);
    always_comb begin
        en = '0;
        unique case (state)
            ST_ALL_OFF:   en = '0;
            ST_IDLE:      en[G_BREAK] = 1'b1;
            ST_TEST_OUT:  en[G_TOUT]  = 1'b1;
            ST_TEST_IN:   en[G_TIN]   = 1'b1;
            ST_TEST_BOTH: begin
                en[G_TIN]  = 1'b1;
                en[G_TOUT] = 1'b1;
            end
            ST_RING:      en[G_RING]  = 1'b1;
            ST_RING_TEST: en[G_RTEST] = 1'b1;
            default:      en = '0;
        endcase
    end
endmodule

// File: rtl/lsw_ctrl.sv
module lsw_ctrl
    import lsw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MODE_W-1:0]    mode_in,
    input  logic                 latch_en,
    input  logic                 sd_drive,
    input  logic                 sd_float,
    input  logic                 thermal_fault,
    output logic [GROUPS-1:0]    sw_en
);
    logic [MODE_W-1:0] mode_eff;
    logic              trip_now;
    logic              force_low;
    line_state_t       state_q;
    line_state_t       state_d;

    lsw_mode_latch #(.W(MODE_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .hold_req (latch_en),
        .mode_d   (mode_in),
        .mode_eff (mode_eff)
    );

    lsw_thermal_trip u_trip (
        .clk       (clk),
        .rst       (rst),
        .fault     (thermal_fault),
        .ctl_float (sd_float),
        .ctl_level (sd_drive),
        .trip_now  (trip_now)
    );

    assign force_low = ~sd_float & ~sd_drive;

    // Next state: OVERRIDE_OFF or DECODE_MOVE.
    always_comb begin
        if (force_low || trip_now) state_d = ST_ALL_OFF;
        else                       state_d = mode_to_state(mode_eff);
    end

    // State register: RESET_ENTRY on reset.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ALL_OFF;
        else     state_q <= state_d;
    end

    lsw_group_drive u_drive (
        .state (state_q),
        .en    (sw_en)
    );
endmodule

// File: rtl/lsw_ctrl_chk.sv
module lsw_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode_in,
    input logic       latch_en,
    input logic       sd_drive,
    input logic       sd_float,
    input logic       thermal_fault,
    input logic [4:0] sw_en
);
    logic rst_q;
    logic seen;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        seen  <= ~rst;
    end

    always @(posedge clk) begin
        if (rst_q) begin
            assert_reset_off_R1: assert (sw_en == 5'b00000)
                else $error("R1 outputs not off after reset");
        end
    end

    assert_idle_decode_R2: assert property (@(posedge clk) disable iff (rst)
        (!latch_en && !sd_float && sd_drive && mode_in == 3'b000) |=> sw_en == 5'b00001);

    assert_unassigned_off_R3: assert property (@(posedge clk) disable iff (rst)
        (!latch_en && !sd_float && sd_drive && mode_in[2:1] == 2'b11) |=> sw_en == 5'b00000);

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (seen && latch_en && $past(latch_en) && !sd_float && sd_drive
         && $past(!sd_float && sd_drive)) |=> $stable(sw_en));

    assert_force_low_off_R6: assert property (@(posedge clk) disable iff (rst)
        (!sd_float && !sd_drive) |=> sw_en == 5'b00000);

    assert_fault_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (!latch_en && !sd_float && sd_drive && thermal_fault && mode_in == 3'b100)
        |=> sw_en == 5'b00010);

    assert_trip_off_R8: assert property (@(posedge clk) disable iff (rst)
        (sd_float && thermal_fault) |=> sw_en == 5'b00000);

    assert_legal_pair_R10: assert property (@(posedge clk) disable iff (rst)
        ($countones(sw_en) <= 1) || (sw_en == 5'b11000));
endmodule

bind lsw_ctrl lsw_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_in       (mode_in),
    .latch_en      (latch_en),
    .sd_drive      (sd_drive),
    .sd_float      (sd_float),
    .thermal_fault (thermal_fault),
    .sw_en         (sw_en)
);

// File: tb/lsw_ctrl_test.sv
module lsw_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_in = 3'b000;
    logic       latch_en = 1'b0;
    logic       sd_drive = 1'b1;
    logic       sd_float = 1'b0;
    logic       thermal_fault = 1'b0;
    logic [4:0] sw_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic       m_le_q  = 1'b0;
    logic [2:0] m_held  = 3'b000;
    logic       m_trip  = 1'b0;
    logic [4:0] exp_en  = 5'b00000;

    lsw_ctrl uut (
        .clk           (clk),
        .rst           (rst),
        .mode_in       (mode_in),
        .latch_en      (latch_en),
        .sd_drive      (sd_drive),
        .sd_float      (sd_float),
        .thermal_fault (thermal_fault),
        .sw_en         (sw_en)
    );

    always #5 clk = ~clk;

    function automatic logic [4:0] table_en(input logic [2:0] m);
        case (m)
            3'b000:  return 5'b00001;
            3'b001:  return 5'b10000;
            3'b010:  return 5'b01000;
            3'b011:  return 5'b11000;
            3'b100:  return 5'b00010;
            3'b101:  return 5'b00100;
            default: return 5'b00000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: sw_en=%b expected %b", tag, act, exp);
        end
    endtask

    // One clock: drive inputs, advance model at the edge, compare at negedge.
    task automatic cyc(input logic [2:0] m, input logic le, input logic drv,
                       input logic flt, input logic flt_fault, input string tag);
        logic       hold;
        logic [2:0] eff;
        logic       trip;
        mode_in = m; latch_en = le; sd_drive = drv; sd_float = flt;
        thermal_fault = flt_fault;
        @(posedge clk);
        hold   = le & m_le_q;
        eff    = hold ? m_held : m;
        m_held = eff;
        m_le_q = le;
        trip   = flt_fault & (flt | (m_trip & ~drv));
        m_trip = trip;
        exp_en = ((!flt && !drv) || trip) ? 5'b00000 : table_en(eff);
        @(negedge clk);
        check(tag, sw_en, exp_en);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [2:0] rm;
        logic       rle, rdrv, rflt, rfault;
        string      tag;
        void'($urandom(32'd20240611));

        // R1: reset, with hold requested during reset
        latch_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", sw_en, 5'b00000);
        rst = 1'b0;
        latch_en = 1'b0;

        // R2 / R3: transparent sweep of all codes
        for (int i = 0; i < 8; i++) begin
            cyc(3'(i), 1'b0, 1'b1, 1'b0, 1'b0, (i >= 6) ? "R3 unassigned" : "R2 decode");
        end

        // R4 capture, R5 hold, R9 release
        cyc(3'b011, 1'b0, 1'b1, 1'b0, 1'b0, "R2 both tests");
        cyc(3'b101, 1'b1, 1'b1, 1'b0, 1'b0, "R4 capture");
        cyc(3'b000, 1'b1, 1'b1, 1'b0, 1'b0, "R5 hold");
        cyc(3'b010, 1'b1, 1'b1, 1'b0, 1'b0, "R5 hold");
        cyc(3'b001, 1'b0, 1'b1, 1'b0, 1'b0, "R9 release");

        // R6: forced low, capture under override appears afterwards
        cyc(3'b000, 1'b0, 1'b0, 1'b0, 1'b0, "R6 forced off");
        cyc(3'b100, 1'b1, 1'b0, 1'b0, 1'b0, "R6 forced off during capture");
        cyc(3'b000, 1'b1, 1'b1, 1'b0, 1'b0, "R6 held mode after override");
        cyc(3'b010, 1'b1, 1'b1, 1'b0, 1'b0, "R5 hold after override");

        // R7: driven high ignores fault
        cyc(3'b000, 1'b0, 1'b1, 1'b0, 1'b1, "R7 fault ignored");

        // R8: trip, sticky across forced low, clear on fault release
        cyc(3'b000, 1'b0, 1'b0, 1'b1, 1'b1, "R8 trip");
        cyc(3'b000, 1'b0, 1'b0, 1'b0, 1'b1, "R8 forced low while tripped");
        cyc(3'b000, 1'b0, 1'b1, 1'b1, 1'b1, "R8 still tripped");
        cyc(3'b010, 1'b0, 1'b0, 1'b1, 1'b0, "R8 fault cleared");
        cyc(3'b100, 1'b0, 1'b0, 1'b1, 1'b1, "R8 trip again");
        cyc(3'b100, 1'b0, 1'b1, 1'b0, 1'b1, "R7 disable clears trip");

        // random phase
        for (int n = 0; n < 2000; n++) begin
            rm     = 3'($urandom_range(0, 7));
            rle    = ($urandom_range(0, 3) == 0);
            rflt   = ($urandom_range(0, 3) == 0);
            rdrv   = ($urandom_range(0, 5) != 0);
            rfault = ($urandom_range(0, 2) == 0);
            if (!rflt && !rdrv)          tag = "R6 random";
            else if (rflt && rfault)     tag = "R8 random";
            else if (rle && m_le_q)      tag = "R5 random";
            else if (rm[2:1] == 2'b11)   tag = "R3 random";
            else                         tag = "R2 random";
            cyc(rm, rle, rdrv, rflt, rfault, tag);
            if ($countones(sw_en) > 1 && sw_en != 5'b11000)
                check("R10 legal set", sw_en, 5'b11000);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule